// File: doc/BRIEF.md
# Keyboard-to-Host Console Bridge

This block is a fixed-program traffic controller that joins three byte-wide peripherals: a keyboard receiver, a serial UART link to a host computer (9600 baud), and the character input of a text display. It is the only master on a small register bus with six port addresses. It never computes anything beyond bit conditioning: outbound keystrokes leave with the top bit forced to one (mark parity), and characters from the host reach the screen with the top bit cleared.

After reset the bridge sends four fixed command writes, which reset and then enable the display and the UART. It then polls forever. Each pass reads the keyboard status and, when a key is waiting, reads the key and writes it to the UART. It then reads the UART status and, when a host character is waiting, reads it and writes it to the display. Each bus transfer is a valid/ready exchange: the bridge raises `bus_req` with address, direction and write data, and the addressed peripheral answers with `bus_ack`. A peripheral may hold `bus_ack` low for any number of cycles. The bridge then keeps every request field unchanged, and read data is taken only in the cycle `bus_ack` is high.

Top module: `kbsb_bridge`

## Requirements
- R1: The bus uses only port addresses 0 to 5. Reads go to 0 (UART status), 1 (UART data), 4 (keyboard status) and 5 (keyboard data). Writes go to 0 (UART command), 1 (UART data), 2 (display command) and 3 (display data).
- R2: After reset, the first four transfers are writes in this order: 0x03 to port 2, 0x03 to port 0, 0x20 to port 2, 0x20 to port 0. No command write follows later.
- R3: Bit 0 of a status byte set to one means a received byte is waiting. When bit 0 is zero, the data port of that path is not read in this pass. Status bits 7..1 have no effect.
- R4: Every keyboard byte b read from port 5 is written next to port 1 as b OR 0x80.
- R5: Every host byte h read from port 1 is written next to port 3 as h AND 0x7F.
- R6: Each pass runs in this order: read port 4; if a key is waiting, read port 5 and then write port 1; read port 0; if a host byte is waiting, read port 1 and then write port 3. Passes repeat without end.
- R7: At most one byte moves in each direction per pass. A burst of host bytes is drained one per pass until all have reached the display.
- R8: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` keep their values into the next cycle.
- R9: `bus_req` is low in the cycle after any cycle with `rst` high.
- R10: The bridge does not check the UART transmitter. If keystrokes arrive at least one character time apart, no write to port 1 happens while the transmitter is still sending the previous character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | output | 1 | Transfer valid |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Port address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Transfer ready; the transfer completes in a cycle where bus_req and bus_ack are both high |
| bus_rdata | input | DATA_W | Read data, valid while bus_ack is high on a read |

## Verification
The bench builds the bridge with DATA_W = 8 and ADDR_W = 3. With these values every one of the 256 byte codes can be sent in each direction, and the parity forcing and stripping are checked against arithmetic expectations. The peripheral stubs withhold `bus_ack` one cycle in four, which exercises the hold rule on every kind of transfer. The status bytes report ones in bits 7..1, so only bit 0 can steer the pass. A scaled character time of 200 cycles on the transmitter stub, with keystrokes 250 cycles apart, puts the unchecked-transmitter condition within reach.

// File: rtl/kbsb_pkg.sv
package kbsb_pkg;
  typedef enum logic [2:0] {
    ST_BOOT,
    ST_INIT,
    ST_KB_STAT,
    ST_KB_DATA,
    ST_KB_SEND,
    ST_HS_STAT,
    ST_HS_DATA,
    ST_HS_SHOW
  } seq_state_t;

  localparam int PORT_HS_CSR   = 0;
  localparam int PORT_HS_DATA  = 1;
  localparam int PORT_VID_CMD  = 2;
  localparam int PORT_VID_DATA = 3;
  localparam int PORT_KB_CSR   = 4;
  localparam int PORT_KB_DATA  = 5;

  localparam int INIT_STEPS = 4;
  localparam int STEP_W     = $clog2(INIT_STEPS);

  localparam logic [7:0] CMD_CLEAR = 8'h03;
  localparam logic [7:0] CMD_READY = 8'h20;
endpackage

// File: rtl/kbsb_seq.sv
module kbsb_seq
  import kbsb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_ack,
  input  logic [DATA_W-1:0]     bus_rdata,
  output seq_state_t            state,
  output logic [STEP_W-1:0]     step,
  output logic [DATA_W-1:0]     held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_BOOT;
      step  <= '0;
      held  <= '0;
    end else begin
      case (state)
        ST_BOOT: state <= ST_INIT;
        ST_INIT: if (bus_ack) begin
          if (step == STEP_W'(INIT_STEPS - 1)) state <= ST_KB_STAT;
          else step <= step + 1'b1;
        end
        ST_KB_STAT: if (bus_ack) state <= bus_rdata[0] ? ST_KB_DATA : ST_HS_STAT;
        ST_KB_DATA: if (bus_ack) begin
          held  <= bus_rdata;
          state <= ST_KB_SEND;
        end
        ST_KB_SEND: if (bus_ack) state <= ST_HS_STAT;
        ST_HS_STAT: if (bus_ack) state <= bus_rdata[0] ? ST_HS_DATA : ST_KB_STAT;
        ST_HS_DATA: if (bus_ack) begin
          held  <= bus_rdata;
          state <= ST_HS_SHOW;
        end
        ST_HS_SHOW: if (bus_ack) state <= ST_KB_STAT;
        default:    state <= ST_BOOT;
      endcase
    end
  end
endmodule

// File: rtl/kbsb_xform.sv
module kbsb_xform #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] marked,
  output logic [DATA_W-1:0] stripped
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] TOP = DATA_W'(1) << MSB;

  assign marked   = din | TOP;
  assign stripped = din & ~TOP;
endmodule

// File: rtl/kbsb_reqgen.sv
module kbsb_reqgen
  import kbsb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  seq_state_t          state,
  input  logic [STEP_W-1:0]   step,
  input  logic [DATA_W-1:0]   marked,
  input  logic [DATA_W-1:0]   stripped,
  output logic                req,
  output logic                we,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   wdata
);
  always_comb begin
    req   = (state != ST_BOOT);
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    case (state)
      ST_INIT: begin
        we    = 1'b1;
        addr  = step[0] ? ADDR_W'(PORT_HS_CSR) : ADDR_W'(PORT_VID_CMD);
        wdata = step[1] ? DATA_W'(CMD_READY) : DATA_W'(CMD_CLEAR);
      end
      ST_KB_STAT: addr = ADDR_W'(PORT_KB_CSR);
      ST_KB_DATA: addr = ADDR_W'(PORT_KB_DATA);
      ST_KB_SEND: begin
        we    = 1'b1;
        addr  = ADDR_W'(PORT_HS_DATA);
        wdata = marked;
      end
      ST_HS_STAT: addr = ADDR_W'(PORT_HS_CSR);
      ST_HS_DATA: addr = ADDR_W'(PORT_HS_DATA);
      ST_HS_SHOW: begin
        we    = 1'b1;
        addr  = ADDR_W'(PORT_VID_DATA);
        wdata = stripped;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/kbsb_bridge.sv
module kbsb_bridge
  import kbsb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  seq_state_t          state;
  logic [STEP_W-1:0]   step;
  logic [DATA_W-1:0]   held, marked, stripped;

  kbsb_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .state(state), .step(step), .held(held)
  );

  kbsb_xform #(.DATA_W(DATA_W)) u_xform (
    .din(held), .marked(marked), .stripped(stripped)
  );

  kbsb_reqgen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_reqgen (
    .state(state), .step(step), .marked(marked), .stripped(stripped),
    .req(bus_req), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata)
  );
endmodule

// File: rtl/kbsb_bridge_chk.sv
module kbsb_bridge_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !bus_req); // R9
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req); // R8
  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R8
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_addr <= ADDR_W'(5)); // R1
  AST_WRITE_PORTS: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we |-> bus_addr <= ADDR_W'(3)); // R1
  AST_MARK_SET: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && bus_addr == ADDR_W'(1) |-> bus_wdata[DATA_W-1]); // R4
  AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && bus_addr == ADDR_W'(3) |-> !bus_wdata[DATA_W-1]); // R5
  AST_CMD_VALUES: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(2))
    |-> (bus_wdata == DATA_W'(8'h03) || bus_wdata == DATA_W'(8'h20))); // R2
endmodule

bind kbsb_bridge kbsb_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/kbsb_bridge_bench.sv
module kbsb_bridge_bench;
  localparam int TX_CHAR = 200;
  localparam int KEY_GAP = 250;
  localparam int EX_KS = 0, EX_KD = 1, EX_UW = 2, EX_HS = 3, EX_HD = 4, EX_DW = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_req, bus_we, bus_ack;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  kbsb_bridge #(.DATA_W(8), .ADDR_W(3)) u_kbsb_bridge (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  // peripheral stubs
  logic [7:0] kb_q [0:511];
  logic [7:0] ux_q [0:511];
  int kb_wp = 0, kb_rp = 0, ux_wp = 0, ux_rp = 0;
  int tx_busy = 0;
  logic [1:0] stall = 2'd0;

  assign bus_ack = bus_req && (stall != 2'd3);

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {7'h7F, ux_rp != ux_wp};
      3'd1:    bus_rdata = ux_q[ux_rp[8:0]];
      3'd4:    bus_rdata = {7'h7F, kb_rp != kb_wp};
      3'd5:    bus_rdata = kb_q[kb_rp[8:0]];
      default: bus_rdata = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    stall <= stall + 2'd1;
    if (tx_busy > 0) tx_busy <= tx_busy - 1;
    if (!rst && bus_req && bus_ack) begin
      if (!bus_we && bus_addr == 3'd5) kb_rp <= kb_rp + 1;
      if (!bus_we && bus_addr == 3'd1) ux_rp <= ux_rp + 1;
      if (bus_we && bus_addr == 3'd1) tx_busy <= TX_CHAR;
    end
  end

  // transaction monitor
  int seq_no = 0, init_n = 0, exp_st = EX_KS;
  int map_viol = 0, ord_viol = 0, tx_viol = 0, hs_viol = 0, kbd_reads = 0;
  int uart_n = 0, disp_n = 0, last_uart_seq = 0, last_disp_seq = 0;
  logic [7:0] uart_log [0:511];
  logic [7:0] disp_log [0:511];
  logic [7:0] init_d [0:3];
  logic [2:0] init_a [0:3];
  logic       init_w [0:3];
  logic [7:0] key_seen, host_seen;
  logic       held_prev = 1'b0, h_we;
  logic [2:0] h_addr;
  logic [7:0] h_wdata;

  always @(negedge clk) begin
    if (held_prev && !rst &&
        (!bus_req || bus_we != h_we || bus_addr != h_addr || bus_wdata != h_wdata))
      hs_viol++;
    held_prev = !rst && bus_req && !bus_ack;
    h_we = bus_we; h_addr = bus_addr; h_wdata = bus_wdata;
    if (!rst && bus_req && bus_ack) begin
      seq_no++;
      if (bus_addr > 3'd5 || (bus_we && bus_addr > 3'd3) ||
          (!bus_we && (bus_addr == 3'd2 || bus_addr == 3'd3))) map_viol++;
      if (bus_we && bus_addr == 3'd1) begin
        uart_log[uart_n] = bus_wdata; uart_n++; last_uart_seq = seq_no;
        if (tx_busy != 0) tx_viol++;
      end
      if (bus_we && bus_addr == 3'd3) begin
        disp_log[disp_n] = bus_wdata; disp_n++; last_disp_seq = seq_no;
      end
      if (!bus_we && bus_addr == 3'd5) kbd_reads++;
      if (init_n < 4) begin
        init_a[init_n] = bus_addr; init_d[init_n] = bus_wdata; init_w[init_n] = bus_we;
        init_n++;
      end else begin
        case (exp_st)
          EX_KS: begin
            if (bus_we || bus_addr != 3'd4) ord_viol++;
            exp_st = bus_rdata[0] ? EX_KD : EX_HS;
          end
          EX_KD: begin
            if (bus_we || bus_addr != 3'd5) ord_viol++;
            key_seen = bus_rdata; exp_st = EX_UW;
          end
          EX_UW: begin
            if (!bus_we || bus_addr != 3'd1 || bus_wdata != (key_seen | 8'h80)) ord_viol++;
            exp_st = EX_HS;
          end
          EX_HS: begin
            if (bus_we || bus_addr != 3'd0) ord_viol++;
            exp_st = bus_rdata[0] ? EX_HD : EX_KS;
          end
          EX_HD: begin
            if (bus_we || bus_addr != 3'd1) ord_viol++;
            host_seen = bus_rdata; exp_st = EX_DW;
          end
          default: begin
            if (!bus_we || bus_addr != 3'd3 || bus_wdata != (host_seen & 8'h7F)) ord_viol++;
            exp_st = EX_KS;
          end
        endcase
      end
    end
  end

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k5;
    @(negedge clk); @(negedge clk);
    check(bus_req == 1'b0, "R9 req low in reset", int'(bus_req), 0);
    @(negedge clk); rst = 1'b0;
    repeat (40) @(negedge clk);

    // R2 reset command sequence
    check(init_n == 4, "R2 init count", init_n, 4);
    check(init_w[0] && init_a[0] == 3'd2 && init_d[0] == 8'h03, "R2 step0", {init_a[0], init_d[0]}, 12'h203);
    check(init_w[1] && init_a[1] == 3'd0 && init_d[1] == 8'h03, "R2 step1", {init_a[1], init_d[1]}, 12'h003);
    check(init_w[2] && init_a[2] == 3'd2 && init_d[2] == 8'h20, "R2 step2", {init_a[2], init_d[2]}, 12'h220);
    check(init_w[3] && init_a[3] == 3'd0 && init_d[3] == 8'h20, "R2 step3", {init_a[3], init_d[3]}, 12'h020);
    check(kbd_reads == 0 && uart_n == 0 && disp_n == 0, "R3 idle passes move nothing",
          kbd_reads + uart_n + disp_n, 0);

    // R4 / R10 keyboard sweep
    for (int b = 0; b < 256; b++) begin
      kb_q[kb_wp[8:0]] = 8'(b); kb_wp++;
      repeat (KEY_GAP) @(negedge clk);
    end
    check(uart_n == 256, "R4 uart write count", uart_n, 256);
    for (int i = 0; i < 256; i++)
      check(uart_log[i] == (8'(i) | 8'h80), "R4 mark parity", int'(uart_log[i]), int'(8'(i) | 8'h80));
    check(tx_viol == 0, "R10 write while transmitter busy", tx_viol, 0);

    // R5 / R7 host burst
    k5 = kbd_reads;
    for (int b = 0; b < 256; b++) begin
      ux_q[ux_wp[8:0]] = 8'(b); ux_wp++;
    end
    for (int t = 0; t < 20000 && ux_rp != ux_wp; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    check(ux_rp == ux_wp, "R7 burst drained", ux_rp, ux_wp);
    check(disp_n == 256, "R5 display write count", disp_n, 256);
    for (int i = 0; i < 256; i++)
      check(disp_log[i] == (8'(i) & 8'h7F), "R5 top bit cleared", int'(disp_log[i]), int'(8'(i) & 8'h7F));
    check(kbd_reads == k5, "R3 no key data read without status bit", kbd_reads - k5, 0);

    // R6 service order with both paths pending
    do @(negedge clk); while (!(bus_req && bus_ack && !bus_we && bus_addr == 3'd0));
    @(negedge clk);
    kb_q[kb_wp[8:0]] = 8'h41; kb_wp++;
    ux_q[ux_wp[8:0]] = 8'hC2; ux_wp++;
    repeat (100) @(negedge clk);
    check(uart_n == 257 && uart_log[256] == 8'hC1, "R4 late key", int'(uart_log[256]), 'hC1);
    check(disp_n == 257 && disp_log[256] == 8'h42, "R5 late host byte", int'(disp_log[256]), 'h42);
    check(last_uart_seq < last_disp_seq, "R6 keyboard path served first", last_uart_seq, last_disp_seq);

    check(ord_viol == 0, "R6 R7 R3 pass order", ord_viol, 0);
    check(map_viol == 0, "R1 port map", map_viol, 0);
    check(hs_viol == 0, "R8 request held under back-pressure", hs_viol, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule